// File: doc/BRIEF.md
# Peripheral Power Domain Controller

This block switches power to a small set of peripherals that sit in their own power domains, and it decides what happens to each peripheral's local SRAM array when the chip goes into deep sleep and comes back. Software programs a one-bit power enable per peripheral and a one-bit memory power choice per peripheral through a simple register port, and it reads back a per-peripheral status word. Two pulse inputs mark deep-sleep entry and wake. The memory state of each array is modelled as a mode (on, retention, off) plus a data-valid flag.

What a memory does on entry depends on a per-peripheral capability table held in parameters: a retention-capable array keeps its data when retention is selected. An array without retention is switched off even if retention is requested. One array (slot 1 by default) may only be switched off when its whole domain is already unpowered; with the domain powered it stays on through deep sleep. A one-beat access probe (request plus slot number) is answered one cycle later with a response pulse that says whether the array was open or blocked.

All control and status pins are plain levels or single-cycle pulses; there is no back-pressure anywhere, so a read or access request is always answered exactly one cycle later.

Top module: `ppd_ctrl`

## Requirements
- R1: After reset every power enable reads 1, every memory control field reads 0, every memory is on with its data-valid flag cleared, and the block is awake.
- R2: A write to the power register (address bits [5:4]=0, index in [3:0]) of a gateable slot sets that slot's `dom_pwr_en` bit to `reg_wdata[0]` from the following cycle; 0 means unpowered.
- R3: Writes to the power register of a slot without its own domain, or of an index beyond the last slot, change no output; such a slot's enable always reads and drives 1.
- R4: On deep-sleep entry a retention-capable memory whose control field (address bits [5:4]=1) is 1 goes to retention (mode code 1) and keeps its data-valid flag.
- R5: On deep-sleep entry a memory whose control field is 0 goes off (mode code 2) and its data-valid flag is cleared.
- R6: A memory without retention capability goes off on entry even when its control field is 1; no such memory ever shows mode code 1.
- R7: The domain-dependent memory stays on through entry while its domain is powered, and goes off on entry while its domain is unpowered.
- R8: On wake every memory returns to on (mode code 0); a retained memory keeps its data-valid flag, a memory that was off comes back with it cleared.
- R9: An access to a slot whose memory is in retention, is off, sits in an unpowered domain, or that has no memory, is answered one cycle later with `acc_rsp_valid` and `acc_rsp_err` both high for one cycle; `mem_blocked` is 1 for exactly those slots.
- R10: An access to an open memory is answered one cycle later with `acc_rsp_err` low and sets that memory's data-valid flag.
- R11: The status register (address bits [5:4]=2) reads bit 3 = domain powered, bit 2 = data valid, bits [1:0] = mode code, other bits 0; a read is answered one cycle after `reg_rd` with `reg_rd_valid`.
- R12: When entry, an access and a register write fall in the same cycle, the entry uses the register values and memory modes from before that cycle, the access is judged against the pre-entry mode, and the write still lands.
- R13: An entry pulse while asleep and a wake pulse while awake are ignored; memory modes change only on an accepted entry or wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register address: [5:4] region, [3:0] slot index |
| reg_wdata | input | 8 | Write data, bit 0 used |
| reg_rd_valid | output | 1 | Read response valid, one cycle after `reg_rd` |
| reg_rd_data | output | 8 | Read response data |
| ds_enter | input | 1 | Deep-sleep entry pulse |
| ds_wake | input | 1 | Wake pulse |
| acc_req | input | 1 | Memory access probe |
| acc_id | input | 3 | Slot addressed by the probe |
| acc_rsp_valid | output | 1 | Access response valid |
| acc_rsp_err | output | 1 | Access rejected |
| dom_pwr_en | output | 6 | Per-slot domain power enable |
| mem_mode | output | 12 | Per-slot memory mode code, two bits per slot |
| mem_blocked | output | 6 | Per-slot access-blocked flag |

## Verification
The interesting collision is deep-sleep entry landing in the same cycle as a memory access and a write to the memory control field of the same slot. The bench arms slot 0 for retention, then raises `ds_enter`, `acc_req` for slot 0 and a write clearing slot 0's control field on one edge. It judges the result by an error-free access response, a status word showing retention with the data-valid flag set (the access counted before entry), and the control field reading back 0 afterwards.

// File: rtl/ppd_pkg.sv
package ppd_pkg;

  typedef enum logic [1:0] {
    MEM_ON  = 2'b00,
    MEM_RET = 2'b01,
    MEM_OFF = 2'b10
  } mem_mode_e;

  typedef enum logic {
    PS_AWAKE = 1'b0,
    PS_DEEP  = 1'b1
  } pwr_state_e;

  localparam logic [1:0] REGION_PWR  = 2'd0;
  localparam logic [1:0] REGION_MCTL = 2'd1;
  localparam logic [1:0] REGION_STAT = 2'd2;

  // status nibble: [3] domain powered, [2] data valid, [1:0] mode
  typedef struct packed {
    logic      dom_on;
    logic      valid;
    mem_mode_e mode;
  } slot_status_t;

endpackage

// File: rtl/ppd_regs.sv
module ppd_regs
  import ppd_pkg::*;
#(
  parameter int              NPER      = 6,
  parameter logic [NPER-1:0] GATE_MASK = '1,
  parameter logic [NPER-1:0] MEM_MASK  = '0,
  parameter int              AW        = 6,
  parameter int              DW        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  input  logic [4*NPER-1:0] status_flat,
  output logic [NPER-1:0]   pwr_en,
  output logic [NPER-1:0]   mem_ctl,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data
);

  localparam int IW = AW - 2;

  logic [1:0]    region;
  logic [IW-1:0] idx;
  logic [DW-1:0] rd_mux;

  assign region = reg_addr[AW-1:AW-2];
  assign idx    = reg_addr[IW-1:0];

  wire unused_wdata = ^reg_wdata[DW-1:1];

  for (genvar p = 0; p < NPER; p++) begin : g_slot
    logic hit_pwr, hit_mctl;
    assign hit_pwr  = reg_wr && (region == REGION_PWR)  && (idx == IW'(p));
    assign hit_mctl = reg_wr && (region == REGION_MCTL) && (idx == IW'(p));

    if (GATE_MASK[p]) begin : g_gate
      logic en_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       en_q <= 1'b1;
        else if (hit_pwr) en_q <= reg_wdata[0];
      end
      assign pwr_en[p] = en_q;
    end else begin : g_fixed
      wire unused_hit = hit_pwr;
      assign pwr_en[p] = 1'b1;
    end

    if (MEM_MASK[p]) begin : g_mctl
      logic ctl_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ctl_q <= 1'b0;
        else if (hit_mctl) ctl_q <= reg_wdata[0];
      end
      assign mem_ctl[p] = ctl_q;
    end else begin : g_noctl
      wire unused_hit = hit_mctl;
      assign mem_ctl[p] = 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int p = 0; p < NPER; p++) begin
      if (idx == IW'(p)) begin
        case (region)
          REGION_PWR:  rd_mux[0]   = pwr_en[p];
          REGION_MCTL: rd_mux[0]   = mem_ctl[p];
          REGION_STAT: rd_mux[3:0] = status_flat[4*p +: 4];
          default:     rd_mux      = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= reg_rd;
      rd_data  <= reg_rd ? rd_mux : '0;
    end
  end

endmodule

// File: rtl/ppd_mem_slot.sv
module ppd_mem_slot
  import ppd_pkg::*;
#(
  parameter bit HAS_MEM  = 1'b1,
  parameter bit RET_CAP  = 1'b0,
  parameter bit DOFF_REQ = 1'b0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enter,
  input  logic      wake,
  input  logic      ctl,
  input  logic      dom_on,
  input  logic      acc_hit,
  output mem_mode_e mode,
  output logic      valid
);

  if (HAS_MEM) begin : g_mem
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mode  <= MEM_ON;
        valid <= 1'b0;
      end else begin
        if (acc_hit) valid <= 1'b1;
        if (enter) begin
          if (DOFF_REQ && dom_on) begin
            mode <= MEM_ON;
          end else if (RET_CAP && ctl) begin
            mode <= MEM_RET;
          end else begin
            mode  <= MEM_OFF;
            valid <= 1'b0;
          end
        end else if (wake) begin
          mode <= MEM_ON;
        end
      end
    end
  end else begin : g_none
    wire unused_slot = ^{clk, rst_n, enter, wake, ctl, dom_on, acc_hit};
    assign mode  = MEM_ON;
    assign valid = 1'b0;
  end

endmodule

// File: rtl/ppd_access.sv
module ppd_access #(
  parameter int NPER = 6,
  parameter int IDW  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_req,
  input  logic [IDW-1:0]  acc_id,
  input  logic [NPER-1:0] blocked,
  output logic [NPER-1:0] acc_hit,
  output logic            rsp_valid,
  output logic            rsp_err
);

  logic sel_blocked;

  always_comb begin
    sel_blocked = 1'b1;
    acc_hit     = '0;
    for (int p = 0; p < NPER; p++) begin
      if (acc_id == IDW'(p)) begin
        sel_blocked = blocked[p];
        acc_hit[p]  = acc_req && !blocked[p];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= acc_req;
      rsp_err   <= acc_req && sel_blocked;
    end
  end

endmodule

// File: rtl/ppd_ctrl.sv
module ppd_ctrl
  import ppd_pkg::*;
#(
  parameter int              NPER      = 6,
  parameter int              IDW       = $clog2(NPER),
  parameter logic [NPER-1:0] GATE_MASK = 6'b011111,
  parameter logic [NPER-1:0] MEM_MASK  = 6'b000111,
  parameter logic [NPER-1:0] RET_MASK  = 6'b000001,
  parameter logic [NPER-1:0] DOFF_MASK = 6'b000010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [5:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic              reg_rd_valid,
  output logic [7:0]        reg_rd_data,
  input  logic              ds_enter,
  input  logic              ds_wake,
  input  logic              acc_req,
  input  logic [IDW-1:0]    acc_id,
  output logic              acc_rsp_valid,
  output logic              acc_rsp_err,
  output logic [NPER-1:0]   dom_pwr_en,
  output logic [2*NPER-1:0] mem_mode,
  output logic [NPER-1:0]   mem_blocked
);

  pwr_state_e        state_q;
  logic              enter_evt, wake_evt;
  logic [NPER-1:0]   mem_ctl;
  logic [NPER-1:0]   acc_hit;
  logic [NPER-1:0]   mem_valid;
  logic [4*NPER-1:0] status_flat;

  assign enter_evt = ds_enter && (state_q == PS_AWAKE);
  assign wake_evt  = ds_wake  && (state_q == PS_DEEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         state_q <= PS_AWAKE;
    else if (enter_evt) state_q <= PS_DEEP;
    else if (wake_evt)  state_q <= PS_AWAKE;
  end

  ppd_regs #(
    .NPER(NPER), .GATE_MASK(GATE_MASK), .MEM_MASK(MEM_MASK), .AW(6), .DW(8)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .status_flat(status_flat),
    .pwr_en(dom_pwr_en), .mem_ctl(mem_ctl),
    .rd_valid(reg_rd_valid), .rd_data(reg_rd_data)
  );

  for (genvar p = 0; p < NPER; p++) begin : g_mem
    mem_mode_e    mode_p;
    slot_status_t st;

    ppd_mem_slot #(
      .HAS_MEM(MEM_MASK[p]), .RET_CAP(RET_MASK[p]), .DOFF_REQ(DOFF_MASK[p])
    ) u_slot (
      .clk(clk), .rst_n(rst_n),
      .enter(enter_evt), .wake(wake_evt),
      .ctl(mem_ctl[p]), .dom_on(dom_pwr_en[p]), .acc_hit(acc_hit[p]),
      .mode(mode_p), .valid(mem_valid[p])
    );

    assign mem_mode[2*p +: 2] = mode_p;
    assign mem_blocked[p]     = !MEM_MASK[p] || (mode_p != MEM_ON) || !dom_pwr_en[p];
    assign st                 = '{dom_on: dom_pwr_en[p], valid: mem_valid[p], mode: mode_p};
    assign status_flat[4*p +: 4] = st;
  end

  ppd_access #(.NPER(NPER), .IDW(IDW)) u_access (
    .clk(clk), .rst_n(rst_n),
    .acc_req(acc_req), .acc_id(acc_id), .blocked(mem_blocked),
    .acc_hit(acc_hit), .rsp_valid(acc_rsp_valid), .rsp_err(acc_rsp_err)
  );

endmodule

// File: rtl/ppd_ctrl_chk.sv
module ppd_ctrl_chk #(
  parameter int              NPER     = 6,
  parameter int              IDW      = 3,
  parameter logic [NPER-1:0] RET_MASK = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic              reg_rd_valid,
  input logic              ds_enter,
  input logic              ds_wake,
  input logic              acc_req,
  input logic [IDW-1:0]    acc_id,
  input logic              acc_rsp_valid,
  input logic              acc_rsp_err,
  input logic [NPER-1:0]   dom_pwr_en,
  input logic [2*NPER-1:0] mem_mode,
  input logic [NPER-1:0]   mem_blocked
);

  logic blocked_sel;
  always_comb begin
    blocked_sel = 1'b1;
    for (int p = 0; p < NPER; p++)
      if (acc_id == IDW'(p)) blocked_sel = mem_blocked[p];
  end

  a_r9_rsp_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rsp_valid |-> $past(acc_req));

  a_r9_blocked_rejected: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && blocked_sel) |=> (acc_rsp_valid && acc_rsp_err));

  a_r10_open_accepted: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && !blocked_sel) |=> (acc_rsp_valid && !acc_rsp_err));

  a_r13_modes_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ds_enter && !ds_wake) |=> $stable(mem_mode));

  a_r2_enable_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> $stable(dom_pwr_en));

  a_r11_read_answers: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_valid |-> $past(reg_rd));

  for (genvar p = 0; p < NPER; p++) begin : g_noret
    if (!RET_MASK[p]) begin : g_chk
      a_r6_no_retention: assert property (@(posedge clk) disable iff (!rst_n)
        mem_mode[2*p +: 2] != 2'b01);
    end
  end

endmodule

bind ppd_ctrl ppd_ctrl_chk #(.NPER(NPER), .IDW(IDW), .RET_MASK(RET_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rd_valid(reg_rd_valid),
  .ds_enter(ds_enter), .ds_wake(ds_wake), .acc_req(acc_req), .acc_id(acc_id),
  .acc_rsp_valid(acc_rsp_valid), .acc_rsp_err(acc_rsp_err),
  .dom_pwr_en(dom_pwr_en), .mem_mode(mem_mode), .mem_blocked(mem_blocked)
);

// File: tb/tb_ppd_ctrl.sv
`timescale 1ns/1ps
module tb_ppd_ctrl;

  localparam int NPER = 6;
  localparam int IDW  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0;
  logic [5:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic reg_rd_valid;
  logic [7:0] reg_rd_data;
  logic ds_enter = 0, ds_wake = 0, acc_req = 0;
  logic [IDW-1:0] acc_id = '0;
  logic acc_rsp_valid, acc_rsp_err;
  logic [NPER-1:0] dom_pwr_en, mem_blocked;
  logic [2*NPER-1:0] mem_mode;

  always #10 clk = ~clk;

  ppd_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rd_valid(reg_rd_valid), .reg_rd_data(reg_rd_data),
    .ds_enter(ds_enter), .ds_wake(ds_wake), .acc_req(acc_req), .acc_id(acc_id),
    .acc_rsp_valid(acc_rsp_valid), .acc_rsp_err(acc_rsp_err),
    .dom_pwr_en(dom_pwr_en), .mem_mode(mem_mode), .mem_blocked(mem_blocked)
  );

  int errors = 0, checks = 0;
  bit done = 0;

  logic [7:0] rd_exp_q[$];
  string      rd_tag_q[$];
  bit         acc_exp_q[$];
  string      acc_tag_q[$];

  function automatic void check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endfunction

  // status word: [3] domain, [2] valid, [1:0] mode
  function automatic logic [7:0] stat(bit dom, bit vld, logic [1:0] md);
    return {4'b0, dom, vld, md};
  endfunction

  // monitor: pops expected responses as they appear
  initial begin
    forever begin
      @(negedge clk);
      if (reg_rd_valid) begin
        if (rd_exp_q.size() == 0) check(0, "R11 unexpected read response", reg_rd_data, 0);
        else begin
          logic [7:0] e; string t;
          e = rd_exp_q.pop_front(); t = rd_tag_q.pop_front();
          check(reg_rd_data == e, t, reg_rd_data, e);
        end
      end
      if (acc_rsp_valid) begin
        if (acc_exp_q.size() == 0) check(0, "R9 unexpected access response", acc_rsp_err, 0);
        else begin
          bit e; string t;
          e = acc_exp_q.pop_front(); t = acc_tag_q.pop_front();
          check(acc_rsp_err == e, t, acc_rsp_err, e);
        end
      end
    end
  end

  task automatic wr(input logic [1:0] rg, input int idx, input bit d);
    @(negedge clk);
    reg_wr = 1; reg_addr = {rg, 4'(idx)}; reg_wdata = {7'b0, d};
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [1:0] rg, input int idx, input logic [7:0] exp, input string tag);
    rd_exp_q.push_back(exp); rd_tag_q.push_back(tag);
    @(negedge clk);
    reg_rd = 1; reg_addr = {rg, 4'(idx)};
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic access(input int id, input bit exp_err, input string tag);
    acc_exp_q.push_back(exp_err); acc_tag_q.push_back(tag);
    @(negedge clk);
    acc_req = 1; acc_id = IDW'(id);
    @(negedge clk);
    acc_req = 0;
  endtask

  task automatic pulse(input bit enter);
    @(negedge clk);
    if (enter) ds_enter = 1; else ds_wake = 1;
    @(negedge clk);
    ds_enter = 0; ds_wake = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check(dom_pwr_en == 6'h3F, "R1 enables", dom_pwr_en, 6'h3F);
    check(mem_mode == 12'h000, "R1 modes", mem_mode, 0);
    check(mem_blocked == 6'h38, "R1 blocked", mem_blocked, 6'h38);
    rd(2'd0, 0, 8'h01, "R1 power reg");
    rd(2'd1, 0, 8'h00, "R1 memctl reg");
    rd(2'd2, 0, stat(1, 0, 2'd0), "R1 R11 status");

    // R2 gateable enable
    wr(2'd0, 3, 0);
    check(dom_pwr_en == 6'h37, "R2 domain off", dom_pwr_en, 6'h37);
    rd(2'd0, 3, 8'h00, "R2 readback");
    wr(2'd0, 3, 1);
    check(dom_pwr_en == 6'h3F, "R2 domain on", dom_pwr_en, 6'h3F);

    // R3 non-gateable and out-of-range
    wr(2'd0, 5, 0);
    wr(2'd0, 7, 0);
    check(dom_pwr_en == 6'h3F, "R3 no effect", dom_pwr_en, 6'h3F);
    rd(2'd0, 5, 8'h01, "R3 fixed reads 1");

    // R10 open accesses set valid; R9 no-memory slot
    access(0, 0, "R10 slot0");
    access(1, 0, "R10 slot1");
    access(2, 0, "R10 slot2");
    access(3, 1, "R9 no memory");
    access(7, 1, "R9 out of range");
    rd(2'd2, 0, stat(1, 1, 2'd0), "R10 valid set");

    // R4 R6 R7 entry with domain 1 powered
    wr(2'd1, 0, 1);
    wr(2'd1, 2, 1);
    pulse(1);
    check(mem_mode == 12'h021, "R4 R6 R7 modes", mem_mode, 12'h021);
    rd(2'd2, 0, stat(1, 1, 2'd1), "R4 retained");
    rd(2'd2, 1, stat(1, 1, 2'd0), "R7 stays on");
    rd(2'd2, 2, stat(1, 0, 2'd2), "R6 off instead");
    check(mem_blocked == 6'h3D, "R9 blocked while asleep", mem_blocked, 6'h3D);
    access(0, 1, "R9 retention rejects");
    access(1, 0, "R10 on memory during sleep");

    // R13 entry while asleep ignored
    wr(2'd1, 0, 0);
    pulse(1);
    check(mem_mode == 12'h021, "R13 entry while asleep", mem_mode, 12'h021);

    // R8 wake
    pulse(0);
    check(mem_mode == 12'h000, "R8 all on", mem_mode, 0);
    rd(2'd2, 0, stat(1, 1, 2'd0), "R8 retained keeps valid");
    rd(2'd2, 2, stat(1, 0, 2'd0), "R8 off comes back empty");
    pulse(0);
    check(mem_mode == 12'h000, "R13 wake while awake", mem_mode, 0);

    // R5 R7 entry with domain 1 unpowered
    wr(2'd0, 1, 0);
    check(mem_blocked == 6'h3A, "R9 domain off blocks", mem_blocked, 6'h3A);
    pulse(1);
    check(mem_mode == 12'h2A, "R5 R7 all off", mem_mode, 12'h2A);
    rd(2'd2, 0, stat(1, 0, 2'd2), "R5 ctl zero off");
    rd(2'd2, 1, stat(0, 0, 2'd2), "R7 domain off powers down");
    pulse(0);
    wr(2'd0, 1, 1);
    rd(2'd2, 1, stat(1, 0, 2'd0), "R8 R7 back on");

    // R12 entry, access and write in one cycle
    wr(2'd1, 0, 1);
    acc_exp_q.push_back(0); acc_tag_q.push_back("R12 access before entry");
    @(negedge clk);
    ds_enter = 1; acc_req = 1; acc_id = 3'd0;
    reg_wr = 1; reg_addr = {2'd1, 4'd0}; reg_wdata = 8'h00;
    @(negedge clk);
    ds_enter = 0; acc_req = 0; reg_wr = 0;
    check(mem_mode[1:0] == 2'd1, "R12 entry used old ctl", mem_mode[1:0], 2'd1);
    rd(2'd2, 0, stat(1, 1, 2'd1), "R12 access counted");
    rd(2'd1, 0, 8'h00, "R12 write landed");
    pulse(0);

    repeat (4) @(negedge clk);
    check(rd_exp_q.size() == 0 && acc_exp_q.size() == 0, "R11 all responses seen",
          rd_exp_q.size() + acc_exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule